// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block is the byte-level command front end of a serial NOR flash target. A bit shifter upstream delivers one received byte per transfer strobe. For each strobe the sequencer registers one response byte, which the shifter sends back on the next transfer. A frame-start pulse marks the assertion of chip select and returns the sequencer to opcode decoding.

The sequencer decodes each opcode and gathers the address and dummy bytes that follow. It then enters one of three modes. In streaming read it returns bytes from the storage array. In streaming program it emits one write request per data byte. In response readout it returns status or identification bytes. It also holds the write-enable latch and passes erase requests to a separate program/erase engine. The storage array sits outside the block. The sequencer drives an address to it and receives the byte at that address on `mem_rdata` in the same cycle.

Dual and quad I/O opcodes change only the number of bytes collected after the opcode. For the dual and quad I/O reads, that number depends on the configured manufacturer byte.

Top module: `spi_flash_cmd_seq`

## Requirements
- R1: After reset, `tx_byte` is 0x00, `wel` is 0, and `pgm_valid`, `er_valid` and `err_op` are 0.
- R2: Opcodes 0x03, 0x02, 0xA2, 0x32, 0x20, 0x52 and 0xD8 collect 3 bytes after the opcode. Opcodes 0x0B, 0x3B and 0x6B collect 4 bytes.
- R3: When the manufacturer byte is 0xEF or 0x01, opcode 0xBB collects 4 bytes and 0xEB collects 6. For any other manufacturer byte, 0xBB collects 5 and 0xEB collects 8.
- R4: The first three collected bytes form the address, most significant byte first, reduced modulo the device size. Further collected bytes are discarded. Once collection ends for a read opcode (0x03, 0x0B, 0x3B, 0x6B, 0xBB, 0xEB), each strobe returns the array byte at the current address, and the address then advances modulo the device size.
- R5: Once collection ends for a program opcode (0x02, 0xA2, 0x32), each strobe raises `pgm_valid` for one cycle. The request carries the current address and the received byte, and the address then advances modulo the device size.
- R6: When the third address byte arrives for opcode 0x20, 0x52 or 0xD8, the block raises `er_valid` for one cycle, but only if `wel` is 1. The request carries `er_kind` 0, 1 or 2 respectively and the collected address. Opcode 0xC7 with `wel` at 1 raises `er_valid` with `er_kind` 3 and address 0. With `wel` at 0, no erase request is issued.
- R7: Opcode 0x06 sets `wel` and opcode 0x04 clears it. Opcode 0x05 returns one byte with `wel` in bit 1 and every other bit zero, and the byte after it is decoded as an opcode.
- R8: Opcode 0x9F returns the manufacturer byte, then the device ID high byte, then the device ID low byte. When the extended ID is nonzero, two more bytes follow: its high byte, then its low byte. After the last byte the next byte is decoded as an opcode.
- R9: Opcode 0x01 with `wel` at 1 collects one byte and then clears `wel`. With `wel` at 0, the opcode is ignored and the next byte is decoded as an opcode.
- R10: A `frame_start` pulse abandons any collection, stream or readout in progress, so the next byte is decoded as an opcode. It clears `tx_byte` and leaves `wel` unchanged.
- R11: The response is 0x00 while decoding opcodes, collecting bytes and programming. An opcode not listed above raises `err_op` for exactly one cycle and leaves the block decoding opcodes. Opcode 0x00 does nothing and raises no error.
- R12: `tx_byte` and `wel` hold their values in any cycle without a strobe or `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse when chip select asserts |
| rx_valid | input | 1 | Transfer strobe: `rx_byte` is valid |
| rx_byte | input | 8 | Byte received from the host |
| tx_byte | output | 8 | Registered response byte |
| mem_addr | output | ADDR_W | Current stream address to the storage array |
| mem_rdata | input | 8 | Array byte at `mem_addr`, same cycle |
| pgm_valid | output | 1 | One-cycle byte program request |
| pgm_addr | output | ADDR_W | Program request address |
| pgm_data | output | 8 | Program request data |
| er_valid | output | 1 | One-cycle erase request |
| er_kind | output | 2 | 0: 4K, 1: 32K, 2: sector, 3: whole chip |
| er_addr | output | ADDR_W | Erase request address |
| wel | output | 1 | Write-enable latch |
| err_op | output | 1 | One-cycle unknown-opcode flag |

## Verification
The assertions assume that `frame_start` and `rx_valid` never coincide, and that `mem_rdata` is a pure function of `mem_addr` in the same cycle. The stimulus meets both conditions. Every transfer starts on the falling edge and lasts exactly one clock, framing pulses are issued in separate cycles, and the array model is a combinational function of the address. Two instances with different manufacturer and extended-ID settings receive identical byte streams, so a single sequence exercises both collection-length variants at once.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  localparam logic [7:0] OPC_NOP    = 8'h00;
  localparam logic [7:0] OPC_WRSR   = 8'h01;
  localparam logic [7:0] OPC_PGM    = 8'h02;
  localparam logic [7:0] OPC_RD     = 8'h03;
  localparam logic [7:0] OPC_WRDI   = 8'h04;
  localparam logic [7:0] OPC_RDSR   = 8'h05;
  localparam logic [7:0] OPC_WREN   = 8'h06;
  localparam logic [7:0] OPC_RDF    = 8'h0B;
  localparam logic [7:0] OPC_ER4K   = 8'h20;
  localparam logic [7:0] OPC_QPGM   = 8'h32;
  localparam logic [7:0] OPC_DRD    = 8'h3B;
  localparam logic [7:0] OPC_ER32K  = 8'h52;
  localparam logic [7:0] OPC_QRD    = 8'h6B;
  localparam logic [7:0] OPC_RDID   = 8'h9F;
  localparam logic [7:0] OPC_DPGM   = 8'hA2;
  localparam logic [7:0] OPC_DIORD  = 8'hBB;
  localparam logic [7:0] OPC_CHIP   = 8'hC7;
  localparam logic [7:0] OPC_ERSEC  = 8'hD8;
  localparam logic [7:0] OPC_QIORD  = 8'hEB;

  localparam logic [1:0] ERK_4K   = 2'd0;
  localparam logic [1:0] ERK_32K  = 2'd1;
  localparam logic [1:0] ERK_SEC  = 2'd2;
  localparam logic [1:0] ERK_CHIP = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_PGM,
    ST_READ,
    ST_OUT
  } sfc_state_t;

  typedef struct packed {
    logic       known;
    logic       collects;
    logic [3:0] need;
    logic       is_read;
    logic       is_pgm;
    logic       is_erase;
    logic [1:0] er_kind;
    logic       is_wrsr;
    logic       is_wren;
    logic       is_wrdi;
    logic       is_rdsr;
    logic       is_rdid;
    logic       is_chip;
  } sfc_op_t;

endpackage

// File: rtl/sfc_opdec.sv
module sfc_opdec
  import sfc_pkg::*;
#(
  parameter logic [7:0] MFR_ID = 8'h20
) (
  input  logic [7:0] opcode,
  output sfc_op_t    dec
);
  localparam bit SHORT_MIO = (MFR_ID == 8'hEF) || (MFR_ID == 8'h01);
  localparam logic [3:0] DIO_NEED = SHORT_MIO ? 4'd4 : 4'd5;
  localparam logic [3:0] QIO_NEED = SHORT_MIO ? 4'd6 : 4'd8;

  always_comb begin
    dec = '0;
    dec.known = 1'b1;
    case (opcode)
      OPC_NOP:  ;
      OPC_WRSR: begin dec.collects = 1'b1; dec.need = 4'd1; dec.is_wrsr = 1'b1; end
      OPC_WRDI: dec.is_wrdi = 1'b1;
      OPC_WREN: dec.is_wren = 1'b1;
      OPC_RDSR: dec.is_rdsr = 1'b1;
      OPC_RDID: dec.is_rdid = 1'b1;
      OPC_CHIP: begin dec.is_chip = 1'b1; dec.er_kind = ERK_CHIP; end
      OPC_RD: begin dec.collects = 1'b1; dec.need = 4'd3; dec.is_read = 1'b1; end
      OPC_RDF, OPC_DRD, OPC_QRD: begin
        dec.collects = 1'b1; dec.need = 4'd4; dec.is_read = 1'b1;
      end
      OPC_DIORD: begin dec.collects = 1'b1; dec.need = DIO_NEED; dec.is_read = 1'b1; end
      OPC_QIORD: begin dec.collects = 1'b1; dec.need = QIO_NEED; dec.is_read = 1'b1; end
      OPC_PGM, OPC_DPGM, OPC_QPGM: begin
        dec.collects = 1'b1; dec.need = 4'd3; dec.is_pgm = 1'b1;
      end
      OPC_ER4K: begin
        dec.collects = 1'b1; dec.need = 4'd3; dec.is_erase = 1'b1; dec.er_kind = ERK_4K;
      end
      OPC_ER32K: begin
        dec.collects = 1'b1; dec.need = 4'd3; dec.is_erase = 1'b1; dec.er_kind = ERK_32K;
      end
      OPC_ERSEC: begin
        dec.collects = 1'b1; dec.need = 4'd3; dec.is_erase = 1'b1; dec.er_kind = ERK_SEC;
      end
      default: dec.known = 1'b0;
    endcase
  end
endmodule

// File: rtl/sfc_readout.sv
module sfc_readout #(
  parameter logic [7:0]  MFR_ID = 8'h20,
  parameter logic [15:0] DEV_ID = 16'h2014,
  parameter logic [15:0] EXT_ID = 16'h0000
) (
  input  logic       sel_id,
  input  logic [2:0] pos,
  input  logic       wel,
  output logic [7:0] data,
  output logic [2:0] id_len
);
  localparam logic [2:0] ID_BYTES = (EXT_ID != 16'h0000) ? 3'd5 : 3'd3;

  assign id_len = ID_BYTES;

  always_comb begin
    if (!sel_id) begin
      data = {6'b0, wel, 1'b0};
    end else begin
      case (pos)
        3'd0:    data = MFR_ID;
        3'd1:    data = DEV_ID[15:8];
        3'd2:    data = DEV_ID[7:0];
        3'd3:    data = EXT_ID[15:8];
        3'd4:    data = EXT_ID[7:0];
        default: data = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/sfc_addr_ctr.sv
module sfc_addr_ctr #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= load_val;
    else if (step) addr <= addr + 1'b1;
  end
endmodule

// File: rtl/spi_flash_cmd_seq.sv
module spi_flash_cmd_seq
  import sfc_pkg::*;
#(
  parameter int          DEV_BYTES = 1 << 20,
  parameter logic [7:0]  MFR_ID    = 8'h20,
  parameter logic [15:0] DEV_ID    = 16'h2014,
  parameter logic [15:0] EXT_ID    = 16'h0000,
  localparam int         ADDR_W    = $clog2(DEV_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic [7:0]        tx_byte,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              pgm_valid,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [7:0]        pgm_data,
  output logic              er_valid,
  output logic [1:0]        er_kind,
  output logic [ADDR_W-1:0] er_addr,
  output logic              wel,
  output logic              err_op
);
  sfc_state_t  state;
  sfc_op_t     dec;
  logic [3:0]  cnt, need;
  logic [2:0]  pos, olen;
  logic        out_id;
  logic [23:0] addr_sh, next_addr;
  logic        cur_read, cur_pgm, cur_erase, cur_wrsr;
  logic [1:0]  cur_kind;
  logic [7:0]  ro_data;
  logic [2:0]  id_len;
  logic        strobe, coll_done, ld_addr, step_addr;

  sfc_opdec #(.MFR_ID(MFR_ID)) u_dec (.opcode(rx_byte), .dec(dec));

  sfc_readout #(.MFR_ID(MFR_ID), .DEV_ID(DEV_ID), .EXT_ID(EXT_ID)) u_ro (
    .sel_id(out_id), .pos(pos), .wel(wel), .data(ro_data), .id_len(id_len)
  );

  assign strobe    = rx_valid && !frame_start;
  assign next_addr = (cnt < 4'd3) ? {addr_sh[15:0], rx_byte} : addr_sh;
  assign coll_done = strobe && (state == ST_COLLECT) && (4'(cnt + 4'd1) == need);
  assign ld_addr   = coll_done && (cur_read || cur_pgm);
  assign step_addr = strobe && ((state == ST_READ) || (state == ST_PGM));

  sfc_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst(rst), .load(ld_addr), .load_val(next_addr[ADDR_W-1:0]),
    .step(step_addr), .addr(mem_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      need      <= '0;
      pos       <= '0;
      olen      <= '0;
      out_id    <= 1'b0;
      addr_sh   <= '0;
      cur_read  <= 1'b0;
      cur_pgm   <= 1'b0;
      cur_erase <= 1'b0;
      cur_wrsr  <= 1'b0;
      cur_kind  <= '0;
      tx_byte   <= '0;
      pgm_valid <= 1'b0;
      pgm_addr  <= '0;
      pgm_data  <= '0;
      er_valid  <= 1'b0;
      er_kind   <= '0;
      er_addr   <= '0;
      wel       <= 1'b0;
      err_op    <= 1'b0;
    end else begin
      pgm_valid <= 1'b0;
      er_valid  <= 1'b0;
      err_op    <= 1'b0;
      if (frame_start) begin
        state   <= ST_IDLE;
        cnt     <= '0;
        pos     <= '0;
        tx_byte <= '0;
      end else if (rx_valid) begin
        case (state)
          ST_IDLE: begin
            tx_byte   <= '0;
            cur_read  <= dec.is_read;
            cur_pgm   <= dec.is_pgm;
            cur_erase <= dec.is_erase;
            cur_wrsr  <= dec.is_wrsr;
            cur_kind  <= dec.er_kind;
            if (!dec.known) begin
              err_op <= 1'b1;
            end else if (dec.is_wren) begin
              wel <= 1'b1;
            end else if (dec.is_wrdi) begin
              wel <= 1'b0;
            end else if (dec.is_chip) begin
              if (wel) begin
                er_valid <= 1'b1;
                er_kind  <= dec.er_kind;
                er_addr  <= '0;
              end
            end else if (dec.is_rdsr || dec.is_rdid) begin
              state  <= ST_OUT;
              pos    <= '0;
              out_id <= dec.is_rdid;
              olen   <= dec.is_rdid ? id_len : 3'd1;
            end else if (dec.collects && (!dec.is_wrsr || wel)) begin
              state <= ST_COLLECT;
              cnt   <= '0;
              need  <= dec.need;
            end
          end
          ST_COLLECT: begin
            tx_byte <= '0;
            cnt     <= 4'(cnt + 4'd1);
            if (cnt < 4'd3) addr_sh <= next_addr;
            if (coll_done) begin
              state <= ST_IDLE;
              if (cur_pgm)  state <= ST_PGM;
              if (cur_read) state <= ST_READ;
              if (cur_erase && wel) begin
                er_valid <= 1'b1;
                er_kind  <= cur_kind;
                er_addr  <= next_addr[ADDR_W-1:0];
              end
              if (cur_wrsr) wel <= 1'b0;
            end
          end
          ST_PGM: begin
            tx_byte   <= '0;
            pgm_valid <= 1'b1;
            pgm_addr  <= mem_addr;
            pgm_data  <= rx_byte;
          end
          ST_READ: begin
            tx_byte <= mem_rdata;
          end
          ST_OUT: begin
            tx_byte <= ro_data;
            pos     <= pos + 3'd1;
            if (pos + 3'd1 == olen) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker (
  input logic       clk,
  input logic       rst,
  input logic       frame_start,
  input logic       rx_valid,
  input logic [7:0] tx_byte,
  input logic       pgm_valid,
  input logic       er_valid,
  input logic       err_op,
  input logic       wel
);
  // R6: an erase request is only issued while the latch is set
  assert_erase_needs_wel_R6: assert property (@(posedge clk) disable iff (rst)
    er_valid |-> wel);

  // R11: request and error pulses never overlap
  assert_pulses_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pgm_valid, er_valid, err_op}));

  // R10: framing clears the response and issues nothing
  assert_frame_clears_R10: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (tx_byte == 8'h00) && !pgm_valid && !er_valid && !err_op);

  // R12: response and latch hold without a strobe
  assert_hold_no_strobe_R12: assert property (@(posedge clk) disable iff (rst)
    (!rx_valid && !frame_start) |=> $stable(tx_byte) && $stable(wel));

  // R5: pulses only follow a strobe
  assert_pulse_needs_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> !pgm_valid && !er_valid && !err_op);
endmodule

bind spi_flash_cmd_seq sfc_checker u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .rx_valid(rx_valid),
  .tx_byte(tx_byte), .pgm_valid(pgm_valid), .er_valid(er_valid),
  .err_op(err_op), .wel(wel)
);

// File: tb/sim_spi_flash_cmd_seq.sv
`timescale 1ns/1ps
module sim_spi_flash_cmd_seq;
  localparam int DEV0 = 1 << 20;
  localparam int DEV1 = 4096;
  localparam int AW0  = 20;
  localparam int AW1  = 12;
  localparam logic [7:0]  MFR0 = 8'h20, MFR1 = 8'hEF;
  localparam logic [15:0] DID0 = 16'h2014, DID1 = 16'h4017;
  localparam logic [15:0] EXT0 = 16'h0000, EXT1 = 16'h4D01;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_start = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = 8'h00;

  logic [7:0] tx0, tx1, rd0, rd1, pd0, pd1;
  logic [AW0-1:0] ma0, pa0, ea0;
  logic [AW1-1:0] ma1, pa1, ea1;
  logic pv0, pv1, ev0, ev1, w0, w1, e0, e1;
  logic [1:0] ek0, ek1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] memf(input int a);
    return 8'((a * 7) + ((a >> 8) * 13) + 8'h35);
  endfunction

  assign rd0 = memf(int'(ma0));
  assign rd1 = memf(int'(ma1));

  spi_flash_cmd_seq #(.DEV_BYTES(DEV0), .MFR_ID(MFR0), .DEV_ID(DID0), .EXT_ID(EXT0)) u0 (
    .clk(clk), .rst(rst), .frame_start(frame_start), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_byte(tx0), .mem_addr(ma0), .mem_rdata(rd0), .pgm_valid(pv0), .pgm_addr(pa0),
    .pgm_data(pd0), .er_valid(ev0), .er_kind(ek0), .er_addr(ea0), .wel(w0), .err_op(e0));

  spi_flash_cmd_seq #(.DEV_BYTES(DEV1), .MFR_ID(MFR1), .DEV_ID(DID1), .EXT_ID(EXT1)) u1 (
    .clk(clk), .rst(rst), .frame_start(frame_start), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_byte(tx1), .mem_addr(ma1), .mem_rdata(rd1), .pgm_valid(pv1), .pgm_addr(pa1),
    .pgm_data(pd1), .er_valid(ev1), .er_kind(ek1), .er_addr(ea1), .wel(w1), .err_op(e1));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Transfers start and end on a falling edge
  task automatic xfer(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic frame();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  function automatic int need_of(input logic [7:0] op, input logic [7:0] mfr);
    bit s = (mfr == 8'hEF) || (mfr == 8'h01);
    case (op)
      8'h03, 8'h02, 8'hA2, 8'h32, 8'h20, 8'h52, 8'hD8: return 3;
      8'h0B, 8'h3B, 8'h6B: return 4;
      8'hBB: return s ? 4 : 5;
      8'hEB: return s ? 6 : 8;
      default: return 0;
    endcase
  endfunction

  // Expected response of transfer j (1-based after opcode) for a read command
  function automatic logic [7:0] rd_exp(input int j, input int n, input int a, input int dev);
    if (j <= n) return 8'h00;
    return memf((a + j - n - 1) & (dev - 1));
  endfunction

  task automatic do_read(input logic [7:0] op, input int a, input int nstream, input string req);
    int n0 = need_of(op, MFR0);
    int n1 = need_of(op, MFR1);
    frame();
    xfer(op);
    for (int j = 1; j <= 8 + nstream; j++) begin
      logic [7:0] b;
      if (j == 1) b = 8'(a >> 16);
      else if (j == 2) b = 8'(a >> 8);
      else if (j == 3) b = 8'(a);
      else b = 8'($urandom);
      xfer(b);
      check(req, tx0, rd_exp(j, n0, a, DEV0));
      check(req, tx1, rd_exp(j, n1, a, DEV1));
    end
  endtask

  task automatic set_wel();
    frame();
    xfer(8'h06);
  endtask

  task automatic do_pgm(input logic [7:0] op, input int a, input int k);
    set_wel();
    frame();
    xfer(op);
    xfer(8'(a >> 16)); xfer(8'(a >> 8)); xfer(8'(a));
    for (int i = 0; i < k; i++) begin
      logic [7:0] d = 8'($urandom);
      xfer(d);
      check("R5 pgm_valid", {pv0, pv1}, 2'b11);
      check("R5 addr u0", pa0, (a + i) & (DEV0 - 1));
      check("R5 addr u1", pa1, (a + i) & (DEV1 - 1));
      check("R5 data", {pd0, pd1}, {d, d});
      check("R11 tx in program", {tx0, tx1}, 16'h0);
    end
  endtask

  task automatic do_erase(input logic [7:0] op, input int a, input logic [1:0] kind, input bit en);
    if (en) set_wel();
    else begin frame(); xfer(8'h04); end
    frame();
    xfer(op);
    xfer(8'(a >> 16)); xfer(8'(a >> 8));
    check("R6 no early erase", {ev0, ev1}, 2'b00);
    xfer(8'(a));
    check("R6 er_valid", {ev0, ev1}, en ? 2'b11 : 2'b00);
    if (en) begin
      check("R6 kind", {ek0, ek1}, {kind, kind});
      check("R6 addr u0", ea0, a & (DEV0 - 1));
      check("R6 addr u1", ea1, a & (DEV1 - 1));
    end
    @(negedge clk);
    check("R6 one cycle", {ev0, ev1}, 2'b00);
  endtask

  initial begin
    #(8.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 tx", {tx0, tx1}, 16'h0);
    check("R1 wel", {w0, w1}, 2'b00);
    check("R1 pulses", {pv0, pv1, ev0, ev1, e0, e1}, 6'h0);

    // R2 / R4 reads with fixed counts, including wrap at end of device
    do_read(8'h03, 24'h012345, 3, "R2 read 03");
    do_read(8'h0B, 24'h000100, 3, "R2 read 0B");
    do_read(8'h3B, 24'hABCDEF, 2, "R2 read 3B");
    do_read(8'h6B, 24'h000010, 2, "R2 read 6B");
    do_read(8'h03, 24'hFFFFFE, 4, "R4 wrap");
    // R3 multi-I/O counts depend on manufacturer byte
    do_read(8'hBB, 24'h00F00D, 3, "R3 read BB");
    do_read(8'hEB, 24'h0A0B0C, 3, "R3 read EB");

    // R7 latch and status
    frame(); xfer(8'h06);
    check("R7 wren", {w0, w1}, 2'b11);
    frame(); xfer(8'h05); xfer(8'h00);
    check("R7 status set", {tx0, tx1}, 16'h0202);
    xfer(8'h00);
    check("R7 back to opcode", {tx0, tx1, e0, e1}, 18'h0);
    frame(); xfer(8'h04);
    check("R7 wrdi", {w0, w1}, 2'b00);
    frame(); xfer(8'h05); xfer(8'h00);
    check("R7 status clear", {tx0, tx1}, 16'h0);

    // R8 identification
    frame(); xfer(8'h9F);
    for (int j = 0; j < 6; j++) begin
      logic [7:0] x0, x1;
      xfer(8'h00);
      case (j)
        0: begin x0 = MFR0; x1 = MFR1; end
        1: begin x0 = DID0[15:8]; x1 = DID1[15:8]; end
        2: begin x0 = DID0[7:0]; x1 = DID1[7:0]; end
        3: begin x0 = 8'h00; x1 = EXT1[15:8]; end
        4: begin x0 = 8'h00; x1 = EXT1[7:0]; end
        default: begin x0 = 8'h00; x1 = 8'h00; end
      endcase
      check("R8 id u0", tx0, x0);
      check("R8 id u1", tx1, x1);
    end

    // R9 write status
    set_wel();
    frame(); xfer(8'h01);
    check("R9 wel held while collecting", {w0, w1}, 2'b11);
    xfer(8'hAA);
    check("R9 wrsr clears wel", {w0, w1}, 2'b00);
    frame(); xfer(8'h01); xfer(8'h05); xfer(8'h00);
    check("R9 ignored without wel", {tx0, tx1}, 16'h0);
    frame(); xfer(8'h06); frame(); xfer(8'h01); xfer(8'h05); xfer(8'h00);
    check("R9 status byte consumed", {tx0, tx1}, 16'h0);

    // R5 programs
    do_pgm(8'h02, 24'h000FFE, 4);
    do_pgm(8'hA2, 24'h123456, 2);
    do_pgm(8'h32, 24'hFFFFFF, 2);

    // R6 erases
    do_erase(8'h20, 24'h034567, 2'd0, 1'b1);
    do_erase(8'h52, 24'h0F8000, 2'd1, 1'b1);
    do_erase(8'hD8, 24'hFFFFFF, 2'd2, 1'b1);
    do_erase(8'h20, 24'h001000, 2'd0, 1'b0);
    set_wel(); frame(); xfer(8'hC7);
    check("R6 chip erase", {ev0, ev1, ek0, ek1}, 6'b11_11_11);
    check("R6 chip addr", {ea0, ea1}, 32'h0);
    frame(); xfer(8'h04); frame(); xfer(8'hC7);
    check("R6 chip erase blocked", {ev0, ev1}, 2'b00);

    // R11 unknown opcode and nop
    frame(); xfer(8'h77);
    check("R11 err pulse", {e0, e1}, 2'b11);
    @(negedge clk);
    check("R11 err one cycle", {e0, e1}, 2'b00);
    xfer(8'h05); xfer(8'h00);
    check("R11 still decoding", {tx0, tx1}, 16'h0);
    frame(); xfer(8'h00);
    check("R11 nop", {e0, e1, tx0, tx1}, 18'h0);

    // R10 framing abandons collection
    frame(); xfer(8'h06);
    frame(); xfer(8'h03); xfer(8'h12); xfer(8'h34);
    frame();
    check("R10 tx cleared", {tx0, tx1}, 16'h0);
    check("R10 wel kept", {w0, w1}, 2'b11);
    xfer(8'h05); xfer(8'h00);
    check("R10 opcode after frame", {tx0, tx1}, 16'h0202);

    // R12 hold without strobe
    frame(); xfer(8'h03); xfer(8'h00); xfer(8'h00); xfer(8'h40); xfer(8'h00);
    repeat (3) @(negedge clk);
    check("R12 hold u0", tx0, memf(32'h40));
    check("R12 hold u1", tx1, memf(32'h40));

    // Random reads and programs
    for (int it = 0; it < 30; it++) begin
      logic [7:0] ops [6] = '{8'h03, 8'h0B, 8'h3B, 8'h6B, 8'hBB, 8'hEB};
      do_read(ops[$urandom_range(0, 5)], int'($urandom & 32'hFFFFFF), int'($urandom_range(1, 5)), "R4 random read");
    end
    for (int it = 0; it < 10; it++) begin
      logic [7:0] pops [3] = '{8'h02, 8'hA2, 8'h32};
      do_pgm(pops[$urandom_range(0, 2)], int'($urandom & 32'hFFFFFF), int'($urandom_range(1, 4)));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule